// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the oversampling clock enable for a serial receiver and transmitter from a fast system clock. The divisor has a 16-bit integer part and a fraction in sixteenths of a clock. Four write-only registers hold the divisor low byte, the divisor high byte, the fraction nibble and a control byte. The control byte selects 8x or 16x oversampling and unlocks writes to the fraction register.

The generator counts system clocks up to the integer divisor. At every reload a 4-bit phase accumulator adds the fraction. An accumulator carry stretches the next sample period by one clock, so sixteen consecutive periods always span exactly sixteen times the integer plus the fraction. A second counter divides the sample ticks by 8 or 16 to give a bit-rate tick. An integer divisor of zero parks the generator. Any register write restarts both counters.

Register map (2-bit address): 0 = divisor bits 7:0, 1 = divisor bits 15:8, 2 = fraction (bits 3:0 used), 3 = control (bit 0 = oversampling select, bit 4 = fraction write unlock).

Top module: `frac_baud_gen`

## Requirements
- R1: For integer divisor D ≥ 1 and fraction F, any 16 consecutive sample-tick periods total exactly 16·D + F clocks.
- R2: Every single sample-tick period is D or D+1 clocks, and is exactly D when F = 0.
- R3: A write to address 2 loads data bits 3:0 into the fraction only while control bit 4 is 1. With bit 4 at 0 the fraction keeps its value. Bits 7:4 of the data are dropped.
- R4: Control bit 0 = 0 selects 8x and = 1 selects 16x. The bit tick is high only together with a sample tick. Counting sample ticks from 1 after a restart, the bit tick fires on every 8th or every 16th one.
- R5: After reset the divisor, fraction, fraction unlock and both ticks are 0, and oversampling is 16x.
- R6: With D ≥ 2, each sample tick is high for exactly one clock.
- R7: While the integer divisor is 0, neither tick is asserted.
- R8: Any write strobe restarts both counters and the accumulator. This includes a blocked fraction write. With D ≥ 1, the first sample tick is visible in the cycle that follows the (D+1)th rising edge after the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| sample_tick_o | output | 1 | Oversampling clock enable, one clock wide |
| bit_tick_o | output | 1 | Bit-rate clock enable, every 8th or 16th sample tick |

## Verification
Two events can land in the same cycle. The bit tick coincides with the sample tick on every 8th or 16th reload. A register write can also arrive while a reload is pending. The bench measures 17 consecutive sample ticks after each restart with mode 8x and 16x, and checks that the bit tick appears on exactly the ticks whose index divides by the ratio and never alone. It also times the first tick after the write that restarts the counters. A stale period or a stale bit-phase count from before the write would move that tick or the bit-tick indices.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned DIV_W   = 16;
  localparam int unsigned FRAC_W  = 4;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned MODE_BIT = 0;
  localparam int unsigned FEN_BIT  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DIV_LO = 2'd0,
    ADDR_DIV_HI = 2'd1,
    ADDR_FRAC   = 2'd2,
    ADDR_CTRL   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int unsigned DIV_WIDTH  = DIV_W,
  parameter int unsigned FRAC_WIDTH = FRAC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DIV_WIDTH-1:0]  div_o,
  output logic [FRAC_WIDTH-1:0] frac_o,
  output logic                  mode16_o,
  output logic                  restart_o
);
  localparam int unsigned HI_W = DIV_WIDTH - DATA_W;

  logic [DATA_W-1:0]     div_lo_q;
  logic [HI_W-1:0]       div_hi_q;
  logic [FRAC_WIDTH-1:0] frac_q;
  logic                  mode16_q;
  logic                  fen_q;
  logic                  restart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_lo_q  <= '0;
      div_hi_q  <= '0;
      frac_q    <= '0;
      mode16_q  <= 1'b1;
      fen_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= wr_en_i;
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_DIV_LO: div_lo_q <= wr_data_i;
          ADDR_DIV_HI: div_hi_q <= wr_data_i[HI_W-1:0];
          ADDR_FRAC:   if (fen_q) frac_q <= wr_data_i[FRAC_WIDTH-1:0];
          default: begin
            mode16_q <= wr_data_i[MODE_BIT];
            fen_q    <= wr_data_i[FEN_BIT];
          end
        endcase
      end
    end
  end

  assign div_o     = {div_hi_q, div_lo_q};
  assign frac_o    = frac_q;
  assign mode16_o  = mode16_q;
  assign restart_o = restart_q;

  // R3
  locked_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_FRAC && !fen_q) |=> $stable(frac_q));
endmodule

// File: rtl/fbg_divider.sv
module fbg_divider #(
  parameter int unsigned DIV_WIDTH  = 16,
  parameter int unsigned FRAC_WIDTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_WIDTH-1:0]  div_i,
  input  logic [FRAC_WIDTH-1:0] frac_i,
  input  logic                  restart_i,
  output logic                  tick_o
);
  localparam int unsigned LIM_W = DIV_WIDTH + 1;

  logic [DIV_WIDTH-1:0]  cnt_q;
  logic [FRAC_WIDTH-1:0] acc_q;
  logic                  ext_q;
  logic                  tick_q;
  logic                  active;
  logic                  hit;
  logic [LIM_W-1:0]      lim;
  logic [FRAC_WIDTH:0]   acc_sum;

  assign active  = (div_i != '0) && !restart_i;
  // period is div, or div+1 after an accumulator carry
  assign lim     = {1'b0, div_i} - LIM_W'(1) + LIM_W'(ext_q);
  assign hit     = active && ({1'b0, cnt_q} == lim);
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      ext_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!active) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      ext_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      acc_q  <= acc_sum[FRAC_WIDTH-1:0];
      ext_q  <= acc_sum[FRAC_WIDTH];
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_WIDTH'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R8
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && acc_q == '0 && !tick_o));
  // R7
  zero_div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |=> !tick_o);
  // R6
  one_cycle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i >= DIV_WIDTH'(2) && !restart_i) |=> !tick_o);
endmodule

// File: rtl/fbg_ratio.sv
module fbg_ratio #(
  parameter int unsigned RATIO_LO = 8,
  parameter int unsigned RATIO_HI = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode16_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic bit_tick_o
);
  localparam int unsigned CNT_W = $clog2(RATIO_HI);

  logic [CNT_W-1:0] scnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign last = mode16_i ? CNT_W'(RATIO_HI - 1) : CNT_W'(RATIO_LO - 1);
  assign wrap = scnt_q >= last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       scnt_q <= '0;
    else if (clear_i)  scnt_q <= '0;
    else if (tick_i)   scnt_q <= wrap ? '0 : scnt_q + CNT_W'(1);
  end

  assign bit_tick_o = tick_i && wrap;

  // R4
  clear_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (scnt_q == '0));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  logic [DIV_W-1:0]  div;
  logic [FRAC_W-1:0] frac;
  logic              mode16;
  logic              restart;

  fbg_regs #(.DIV_WIDTH(DIV_W), .FRAC_WIDTH(FRAC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .div_o(div), .frac_o(frac), .mode16_o(mode16), .restart_o(restart)
  );

  fbg_divider #(.DIV_WIDTH(DIV_W), .FRAC_WIDTH(FRAC_W)) u_div (
    .clk_i, .rst_ni, .div_i(div), .frac_i(frac), .restart_i(restart),
    .tick_o(sample_tick_o)
  );

  fbg_ratio #(.RATIO_LO(8), .RATIO_HI(16)) u_ratio (
    .clk_i, .rst_ni, .mode16_i(mode16),
    .clear_i(restart || div == '0),
    .tick_i(sample_tick_o), .bit_tick_o
  );

  // R4
  bit_in_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       sample_tick_o, bit_tick_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  frac_baud_gen uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = 2'(addr);
    wr_data_i = 8'(data);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  function automatic int total_exp(int dv, int fr);
    return 16 * dv + fr;
  endfunction

  // called on the negedge right after the restarting write
  task automatic measure(int dv, int fr, int ratio);
    int k = 0;
    int n = 0;
    int t1 = 0;
    int tp = 0;
    bit prev = 0;
    int limit = (dv + 2) * 18 + 10;
    while (n < 17 && k < limit) begin
      @(negedge clk_i);
      k++;
      if (sample_tick_o) begin
        n++;
        if (n == 1) begin
          check(k == dv + 1, "R8 first tick latency", k, dv + 1);
          t1 = k;
        end else begin
          if (fr == 0) check(k - tp == dv, "R2 period", k - tp, dv);
          else check(k - tp == dv || k - tp == dv + 1, "R2 period", k - tp, dv);
        end
        if (n == 17) check(k - t1 == total_exp(dv, fr), "R1 16-period sum", k - t1, total_exp(dv, fr));
        check(bit_tick_o == ((n % ratio) == 0), "R4 bit tick index", int'(bit_tick_o), int'((n % ratio) == 0));
        if (prev && dv >= 2) check(0, "R6 tick width", 2, 1);
        tp = k;
      end else if (bit_tick_o) begin
        check(0, "R4 bit tick without sample", 1, 0);
      end
      prev = sample_tick_o;
    end
    check(n == 17, "R1 tick count", n, 17);
  endtask

  task automatic run_case(int dv, int fr, bit m16);
    wr(3, 8'h10 | int'(m16));
    wr(2, fr);
    wr(1, dv >> 8);
    wr(0, dv & 8'hff);
    measure(dv, fr & 15, m16 ? 16 : 8);
  endtask

  task automatic idle_check(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (sample_tick_o || bit_tick_o) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd2750);
    seed = seed;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R5: reset values, divisor 0 means silence
    check(!sample_tick_o && !bit_tick_o, "R5 reset ticks", int'(sample_tick_o), 0);
    idle_check(40, "R5 idle after reset");
    // R5: default mode 16x and fraction 0 without touching control
    wr(0, 5);
    measure(5, 0, 16);
    // R3: fraction write blocked while unlock bit is 0 (still reset value)
    wr(2, 7);
    measure(5, 0, 16);

    run_case(1, 0, 1'b1);
    run_case(1, 15, 1'b0);
    run_case(2, 8, 1'b0);
    run_case(3, 1, 1'b1);
    run_case(261, 9, 1'b1);
    // R3: upper data bits dropped
    run_case(6, 8'hf3, 1'b0);

    // R3: lock fraction, blocked write, restart via low byte
    wr(3, 8'h01);
    wr(2, 12);
    wr(0, 6);
    measure(6, 3, 16);
    // R8: blocked fraction write still restarts
    wr(2, 9);
    measure(6, 3, 16);

    // R7: zero divisor
    wr(1, 0);
    wr(0, 0);
    idle_check(100, "R7 zero divisor idle");

    for (int i = 0; i < 8; i++) begin
      int dv = 1 + int'($urandom_range(59));
      int fr = int'($urandom_range(255));
      bit m  = 1'($urandom_range(1));
      run_case(dv, fr, m);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule